// File: doc/BRIEF.md
# Framed Serial Transmitter with Line Control

This block turns parallel bytes into asynchronous serial frames. A byte written into a single-entry holding register moves into a shift register once the line is idle. The shift register sends a low start bit, then the data bits least significant first, then an optional parity bit, then one or more stop bits. Each bit lasts a fixed number of oversampling ticks. A separate baud generator supplies these ticks as a one-cycle enable.

The line-control inputs select the word length (5 to 8 bits), the stop-bit count, and the parity behaviour. Parity can be off, even, odd, or held at a constant value. A break input holds the line low. The block reports whether the holding register is free and whether both registers have drained.

The frame configuration is captured when a byte enters the shift register. The break input acts on the line at once. Reset is asserted asynchronously, and its release is synchronised to the clock inside the block.

Top module: `uart_line_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress and break is off, `txd` is 1. After reset, `hold_empty` and `tx_empty` are both 1.
- R2: Each frame begins with exactly one 0 bit, followed by the data bits LSB first. The number of data bits comes from `cfg_wlen`: 2'b00 gives 5, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8.
- R3: When `cfg_par_en` is 1 and `cfg_par_stick` is 0, one parity bit follows the data. With `cfg_par_even` = 1, the data ones plus the parity bit total an even number. With `cfg_par_even` = 0, they total an odd number. When `cfg_par_en` is 0, the first stop bit follows the data directly.
- R4: When `cfg_par_en` and `cfg_par_stick` are both 1, the parity bit equals `cfg_par_even`, whatever the data.
- R5: Every bit lasts 16 baud ticks, and stop bits are 1. With `cfg_two_stop` = 0 there is one stop bit. With `cfg_two_stop` = 1 there are two stop bits for 6, 7 or 8 bit words, and one and a half (24 ticks) for 5-bit words. `tx_empty` rises on the final tick of the frame and not earlier.
- R6: While `cfg_break` is 1, `txd` is 0, whether the block is idle or mid-frame. Clearing it restores the normal line value at once.
- R7: `hold_empty` goes to 0 on the clock edge that accepts `wr_en`. It returns to 1 on the first baud tick at which the shift register is idle, and that same tick starts the start bit.
- R8: `tx_empty` is 1 only when both the holding register and the shift register are empty. It is 0 from the write until the last stop bit completes.
- R9: A byte written while a frame is in progress waits in the holding register. Its start bit begins on the first baud tick after the previous frame's final tick, which is exactly one tick later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle oversampling enable, 16 per bit |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| cfg_wlen | input | 2 | Word length code (5 + value data bits) |
| cfg_two_stop | input | 1 | Extended stop period select |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_even | input | 1 | Even parity select, also the stuck value |
| cfg_par_stick | input | 1 | Hold the parity bit at a constant |
| cfg_break | input | 1 | Force the serial line low |
| txd | output | 1 | Serial output, idle high |
| hold_empty | output | 1 | Holding register has no pending byte |
| tx_empty | output | 1 | Holding and shift registers both empty |

## Verification
A wrong bit-phase or tick counter shows up in `txd` within one bit time. The bench therefore samples every bit at its centre, measured in ticks from the falling edge of the start bit, so a bit that starts early or late, or has the wrong value, is reported in that same bit. The exact tick on which `tx_empty` rises, checked one tick before and at the end, exposes a wrong stop length or a missing or extra parity bit by the end of the frame. A lost or early holding-register handoff appears immediately on `hold_empty`, or one tick after a frame ends as a wrong start time for the waiting byte.

// File: rtl/uart_ltx_pkg.sv
package uart_ltx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_START  = 3'd1,
    PH_DATA   = 3'd2,
    PH_PARITY = 3'd3,
    PH_STOP1  = 3'd4,
    PH_STOP2  = 3'd5
  } phase_e;

  typedef struct packed {
    logic [1:0] wlen;
    logic       two_stop;
    logic       par_en;
    logic       par_even;
    logic       par_stick;
  } line_cfg_t;

endpackage

// File: rtl/uart_ltx_hold.sv
module uart_ltx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);

  logic              full_d;
  logic [DATA_W-1:0] data_d;

  // A write in the same cycle as a handoff keeps the entry occupied.
  always_comb begin
    full_d = full;
    data_d = data;
    if (take) full_d = 1'b0;
    if (wr_en) begin
      full_d = 1'b1;
      data_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      full <= full_d;
      if (wr_en) data <= data_d;
    end
  end

  // R7: a handoff only ever drains an occupied entry
  a_r7_take_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full);

endmodule

// File: rtl/uart_ltx_parity.sv
module uart_ltx_parity #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0]         data,
  input  logic [$clog2(DATA_W)-1:0] last_idx,
  input  logic                      par_even,
  input  logic                      par_stick,
  output logic                      par_bit
);

  localparam int IDX_W = $clog2(DATA_W);

  logic [DATA_W-1:0] masked;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign masked[i] = data[i] & (IDX_W'(i) <= last_idx);
  end

  always_comb begin
    if (par_stick)     par_bit = par_even;
    else if (par_even) par_bit = ^masked;
    else               par_bit = ~(^masked);
  end

endmodule

// File: rtl/uart_ltx_frame.sv
module uart_ltx_frame
  import uart_ltx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  line_cfg_t         cfg,
  output logic              take,
  output logic              busy,
  output logic              line_bit
);

  localparam int CNT_W    = $clog2(TICKS_PER_BIT);
  localparam int IDX_W    = $clog2(DATA_W);
  localparam int MIN_WORD = DATA_W - 3;
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(TICKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(TICKS_PER_BIT / 2 - 1);

  phase_e            phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [IDX_W-1:0]  last_q, last_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              par_q, par_d;
  logic              pen_q, pen_d;
  logic              two_q, two_d;
  logic              half_q, half_d;

  logic [IDX_W-1:0]  cfg_last;
  logic              par_new;
  logic              bit_end;
  logic              step;
  logic              reg_en;

  assign cfg_last = IDX_W'(MIN_WORD - 1) + IDX_W'(cfg.wlen);

  uart_ltx_parity #(.DATA_W(DATA_W)) u_parity (
    .data      (hold_data),
    .last_idx  (cfg_last),
    .par_even  (cfg.par_even),
    .par_stick (cfg.par_stick),
    .par_bit   (par_new)
  );

  assign busy    = (phase_q != PH_IDLE);
  assign take    = baud_tick && !busy && hold_full;
  assign step    = baud_tick && busy;
  assign reg_en  = take || step;
  assign bit_end = step &&
    (cnt_q == (((phase_q == PH_STOP2) && half_q) ? HALF_LAST : FULL_LAST));

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    last_d  = last_q;
    sh_d    = sh_q;
    par_d   = par_q;
    pen_d   = pen_q;
    two_d   = two_q;
    half_d  = half_q;
    if (take) begin
      phase_d = PH_START;
      cnt_d   = '0;
      idx_d   = '0;
      last_d  = cfg_last;
      sh_d    = hold_data;
      par_d   = par_new;
      pen_d   = cfg.par_en;
      two_d   = cfg.two_stop;
      half_d  = cfg.two_stop && (cfg.wlen == 2'b00);
    end else if (step) begin
      cnt_d = cnt_q + 1'b1;
      if (bit_end) begin
        cnt_d = '0;
        unique case (phase_q)
          PH_START: begin
            phase_d = PH_DATA;
            idx_d   = '0;
          end
          PH_DATA: begin
            sh_d = sh_q >> 1;
            if (idx_q == last_q) phase_d = pen_q ? PH_PARITY : PH_STOP1;
            else                 idx_d   = idx_q + 1'b1;
          end
          PH_PARITY: phase_d = PH_STOP1;
          PH_STOP1:  phase_d = two_q ? PH_STOP2 : PH_IDLE;
          PH_STOP2:  phase_d = PH_IDLE;
          default:   phase_d = PH_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      last_q  <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      pen_q   <= 1'b0;
      two_q   <= 1'b0;
      half_q  <= 1'b0;
    end else if (reg_en) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      last_q  <= last_d;
      sh_q    <= sh_d;
      par_q   <= par_d;
      pen_q   <= pen_d;
      two_q   <= two_d;
      half_q  <= half_d;
    end
  end

  always_comb begin
    unique case (phase_q)
      PH_START:  line_bit = 1'b0;
      PH_DATA:   line_bit = sh_q[0];
      PH_PARITY: line_bit = par_q;
      default:   line_bit = 1'b1;
    endcase
  end

  // R5: the shortened final stop never runs past half a bit
  a_r5_half_window: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_STOP2 && half_q) |-> (cnt_q <= HALF_LAST));

  // R5: bit timing advances only on baud ticks
  a_r5_tick_paced: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !baud_tick) |=> ($stable(phase_q) && $stable(cnt_q)));

  // R2: the data index never passes the configured last bit
  a_r2_index_range: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DATA) |-> (idx_q <= last_q));

  // R3: a parity slot appears only when parity was enabled for this frame
  a_r3_parity_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_PARITY) |-> pen_q);

endmodule

// File: rtl/uart_line_tx.sv
module uart_line_tx
  import uart_ltx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        cfg_wlen,
  input  logic              cfg_two_stop,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  input  logic              cfg_par_stick,
  input  logic              cfg_break,
  output logic              txd,
  output logic              hold_empty,
  output logic              tx_empty
);

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic              take;
  logic              busy;
  logic              line_bit;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  line_cfg_t         cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign cfg = '{wlen: cfg_wlen, two_stop: cfg_two_stop, par_en: cfg_par_en,
                 par_even: cfg_par_even, par_stick: cfg_par_stick};

  uart_ltx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .take    (take),
    .full    (hold_full),
    .data    (hold_data)
  );

  uart_ltx_frame #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT)) u_frame (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .baud_tick (baud_tick),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .cfg       (cfg),
    .take      (take),
    .busy      (busy),
    .line_bit  (line_bit)
  );

  assign txd        = cfg_break ? 1'b0 : line_bit;
  assign hold_empty = !hold_full;
  assign tx_empty   = !hold_full && !busy;

  // R7: an accepted write always occupies the holding register
  a_r7_write_fills: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en |=> !hold_empty);

  // R7: an idle tick with a pending byte drains it and starts a frame
  a_r7_handoff: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (baud_tick && !busy && hold_full && !wr_en) |=> (hold_empty && busy));

  // R1: an idle line without break rests high
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy && !cfg_break) |-> txd);

  // R8: fully drained means the line carries no frame bits
  a_r8_drained_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tx_empty |-> (txd || cfg_break));

endmodule

// File: tb/tb_uart_line_tx.sv
module tb_uart_line_tx;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 3;
  localparam int TPB        = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] cfg_wlen = 2'b00;
  logic       cfg_two_stop = 1'b0;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_even = 1'b0;
  logic       cfg_par_stick = 1'b0;
  logic       cfg_break = 1'b0;
  logic       txd;
  logic       hold_empty;
  logic       tx_empty;

  int n_chk = 0;
  int n_bad = 0;
  int tick_seen = 0;
  int t0 = 0;
  int div = 0;
  bit tick_run = 1'b0;

  uart_line_tx dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .baud_tick     (baud_tick),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .cfg_wlen      (cfg_wlen),
    .cfg_two_stop  (cfg_two_stop),
    .cfg_par_en    (cfg_par_en),
    .cfg_par_even  (cfg_par_even),
    .cfg_par_stick (cfg_par_stick),
    .cfg_break     (cfg_break),
    .txd           (txd),
    .hold_empty    (hold_empty),
    .tx_empty      (tx_empty)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (tick_run) begin
      baud_tick <= (div == 0);
      div <= (div == TICK_DIV - 1) ? 0 : div + 1;
    end else begin
      baud_tick <= 1'b0;
    end
  end

  always @(posedge clk) if (baud_tick) tick_seen <= tick_seen + 1;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  function automatic int frame_ticks(int wl, bit ts, bit pe);
    int n = 5 + wl;
    int t = TPB * (1 + n + (pe ? 1 : 0) + 1);
    if (ts) t += (n == 5) ? TPB / 2 : TPB;
    return t;
  endfunction

  function automatic logic exp_par(logic [7:0] d, int n, bit ev, bit st);
    int ones = 0;
    for (int i = 0; i < n; i++) ones += d[i];
    if (st) return ev;
    return ev ? logic'(ones % 2 == 1) : logic'(ones % 2 == 0);
  endfunction

  task automatic set_cfg(int wl, bit ts, bit pe, bit ev, bit st);
    @(negedge clk);
    cfg_wlen = 2'(wl);
    cfg_two_stop = ts;
    cfg_par_en = pe;
    cfg_par_even = ev;
    cfg_par_stick = st;
  endtask

  task automatic write_byte(logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    chk(hold_empty == 1'b0, "R7", "hold_empty after write", int'(hold_empty), 0);
    chk(tx_empty == 1'b0, "R8", "tx_empty after write", int'(tx_empty), 0);
  endtask

  task automatic wait_start();
    while (txd !== 1'b0) @(negedge clk);
    t0 = tick_seen;
  endtask

  task automatic wait_rel(int k);
    while (tick_seen - t0 < k) @(negedge clk);
  endtask

  task automatic check_bits(logic [7:0] d, int wl, bit ts, bit pe, bit ev, bit st, string preq);
    int n = 5 + wl;
    int b;
    int t = frame_ticks(wl, ts, pe);
    wait_rel(TPB / 2);
    chk(txd == 1'b0, "R2", "start bit", int'(txd), 0);
    for (int i = 0; i < n; i++) begin
      wait_rel(TPB * (i + 1) + TPB / 2);
      chk(txd == d[i], "R2", $sformatf("data bit %0d", i), int'(txd), int'(d[i]));
    end
    b = n + 1;
    if (pe) begin
      wait_rel(TPB * b + TPB / 2);
      chk(txd == exp_par(d, n, ev, st), preq, "parity bit", int'(txd), int'(exp_par(d, n, ev, st)));
      b++;
    end
    wait_rel(TPB * b + TPB / 2);
    chk(txd == 1'b1, "R5", "first stop bit", int'(txd), 1);
    if (ts) begin
      wait_rel(TPB * (b + 1) + ((n == 5) ? TPB / 4 : TPB / 2));
      chk(txd == 1'b1, "R5", "extra stop period", int'(txd), 1);
    end
    wait_rel(t - 1);
    chk(tx_empty == 1'b0, "R5", "busy one tick before frame end", int'(tx_empty), 0);
  endtask

  task automatic send_frame(logic [7:0] d, int wl, bit ts, bit pe, bit ev, bit st, string preq);
    set_cfg(wl, ts, pe, ev, st);
    write_byte(d);
    wait_start();
    chk(hold_empty == 1'b1, "R7", "hold_empty at start bit", int'(hold_empty), 1);
    check_bits(d, wl, ts, pe, ev, st, preq);
    wait_rel(frame_ticks(wl, ts, pe));
    chk(tx_empty == 1'b1, "R8", "tx_empty at frame end", int'(tx_empty), 1);
    chk(txd == 1'b1, "R1", "idle line after frame", int'(txd), 1);
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    chk(txd == 1'b1, "R1", "txd in reset", int'(txd), 1);
    chk(hold_empty == 1'b1, "R1", "hold_empty in reset", int'(hold_empty), 1);
    chk(tx_empty == 1'b1, "R1", "tx_empty in reset", int'(tx_empty), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    tick_run = 1'b1;
    repeat (10) @(negedge clk);
    chk(txd == 1'b1, "R1", "txd after reset", int'(txd), 1);
    chk(tx_empty == 1'b1, "R1", "tx_empty after reset", int'(tx_empty), 1);
  endtask

  task automatic test_word_lengths();
    send_frame(8'hA5, 0, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
    send_frame(8'h96, 1, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
    send_frame(8'h3C, 2, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
    send_frame(8'hC3, 3, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
  endtask

  task automatic test_parity();
    send_frame(8'hB1, 3, 1'b0, 1'b1, 1'b1, 1'b0, "R3");
    send_frame(8'hB1, 3, 1'b0, 1'b1, 1'b0, 1'b0, "R3");
    send_frame(8'hE6, 1, 1'b0, 1'b1, 1'b1, 1'b0, "R3");
    send_frame(8'h0F, 0, 1'b0, 1'b1, 1'b0, 1'b0, "R3");
  endtask

  task automatic test_stick();
    send_frame(8'h01, 3, 1'b0, 1'b1, 1'b1, 1'b1, "R4");
    send_frame(8'h07, 2, 1'b0, 1'b1, 1'b0, 1'b1, "R4");
  endtask

  task automatic test_stops();
    send_frame(8'h15, 0, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
    send_frame(8'h55, 2, 1'b1, 1'b1, 1'b1, 1'b0, "R3");
    send_frame(8'h2A, 0, 1'b1, 1'b1, 1'b0, 1'b1, "R4");
  endtask

  task automatic test_break();
    int viol = 0;
    int guard = 0;
    @(negedge clk);
    cfg_break = 1'b1;
    @(negedge clk);
    chk(txd == 1'b0, "R6", "break while idle", int'(txd), 0);
    set_cfg(3, 1'b0, 1'b0, 1'b0, 1'b0);
    write_byte(8'hFF);
    while (tx_empty !== 1'b1 && guard < 5000) begin
      if (txd !== 1'b0) viol++;
      guard++;
      @(negedge clk);
    end
    chk(viol == 0, "R6", "line high during break frame", viol, 0);
    chk(guard > TPB * TICK_DIV, "R6", "frame still ran under break", guard, TPB * TICK_DIV + 1);
    cfg_break = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R6", "release from idle break", int'(txd), 1);
    write_byte(8'hFF);
    wait_start();
    wait_rel(TPB * 3 + TPB / 2);
    chk(txd == 1'b1, "R2", "all-ones data bit", int'(txd), 1);
    cfg_break = 1'b1;
    @(negedge clk);
    chk(txd == 1'b0, "R6", "break mid-frame", int'(txd), 0);
    cfg_break = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R6", "release mid-frame", int'(txd), 1);
    wait_rel(frame_ticks(3, 1'b0, 1'b0));
    chk(tx_empty == 1'b1, "R8", "empty after break test", int'(tx_empty), 1);
  endtask

  task automatic test_back_to_back();
    int first_t0;
    int t = frame_ticks(1, 1'b0, 1'b1);
    set_cfg(1, 1'b0, 1'b1, 1'b1, 1'b0);
    write_byte(8'h2D);
    wait_start();
    first_t0 = t0;
    write_byte(8'h12);
    check_bits(8'h2D, 1, 1'b0, 1'b1, 1'b1, 1'b0, "R3");
    wait_rel(t);
    chk(tx_empty == 1'b0, "R9", "tx_empty with byte pending", int'(tx_empty), 0);
    chk(hold_empty == 1'b0, "R9", "second byte still held", int'(hold_empty), 0);
    chk(txd == 1'b1, "R9", "idle gap tick", int'(txd), 1);
    wait_start();
    chk(t0 - first_t0 == t + 1, "R9", "second start tick", t0 - first_t0, t + 1);
    chk(hold_empty == 1'b1, "R7", "held byte drained", int'(hold_empty), 1);
    check_bits(8'h12, 1, 1'b0, 1'b1, 1'b1, 1'b0, "R3");
    wait_rel(t);
    chk(tx_empty == 1'b1, "R8", "empty after pair", int'(tx_empty), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    test_reset();
    test_word_lengths();
    test_parity();
    test_stick();
    test_stops();
    test_break();
    test_back_to_back();
    summary();
    $finish;
  end

endmodule